// File: doc/BRIEF.md
# Packet-Aware Serial Link Rate Selector

This block paces the transmitter of a serial link. It produces a one-cycle bit enable, taken from a fast base clock, at one of four rates. Two rate codes are programmed separately: one for bits sent inside a packet and one for the idle link between packets. Running the idle link slowly saves power when traffic is light.

The transmitter marks the first bit of each packet with `pkt_start` and the last bit sent with `pkt_end`. At each of these boundaries the selector takes a fresh copy of the matching rate code, the in-packet code at a start and the idle code at an end. It changes the rate only when the current bit period has run out, so no enable period is ever cut short. The code the link is running at is brought out on `rate_code`.

Top module: `link_rate_sel`

## Requirements
- R1: After reset `rate_code` is 2'b11 (divide by 10). The first `bit_en` pulse comes on the tenth clock cycle after reset is released.
- R2: The code gives the spacing of `bit_en` pulses: 2'b00 pulses on every cycle, 2'b01 on every 2nd, 2'b10 on every 4th and 2'b11 on every 10th. Each pulse lasts one cycle.
- R3: A cycle with `pkt_start` high takes `busy_rate` as the pending code. A cycle with `pkt_end` high and `pkt_start` low takes `idle_rate` as the pending code. When both are high, `pkt_start` wins.
- R4: `rate_code` changes only on a clock edge that follows a cycle with `bit_en` high. At that edge it loads the pending code, including a code taken in that same cycle.
- R5: Changes on `busy_rate` and `idle_rate` between boundaries have no effect on `rate_code` or `bit_en` until the next `pkt_start` or `pkt_end`.
- R6: After a rate change, the first `bit_en` at the new rate comes one full new period after the last pulse at the old rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | First bit of a packet is being sent |
| pkt_end | input | 1 | Last bit of a packet has been sent |
| busy_rate | input | 2 | Rate code used inside packets |
| idle_rate | input | 2 | Rate code used between packets |
| bit_en | output | 1 | One-cycle transmit bit enable |
| rate_code | output | 2 | Rate code currently in force |

## Verification
The assertions check several rules on every cycle. The divider count stays below the current divisor. A pulse at a slow rate is never followed by another pulse on the next cycle. `rate_code` only moves after an enable. The pending code follows the boundary rules and holds steady between boundaries. Only the bench's scenarios can show the exact pulse spacing for each code, the length of the first period after reset, the start-over-end priority, and that rate edits in the middle of a packet stay hidden until the next boundary. It does this by comparing both outputs cycle by cycle against a period model worked out from the requirements.

// File: rtl/link_rate_pkg.sv
package link_rate_pkg;
  localparam int CODE_W = 2;
  localparam int CNT_W  = 4;

  typedef logic [CODE_W-1:0] rate_code_t;

  localparam rate_code_t RATE_SLOWEST = 2'b11;

  // Base-clock cycles per bit for each rate code.
  function automatic logic [CNT_W-1:0] rate_div(input rate_code_t code);
    case (code)
      2'b00:   rate_div = 4'd1;
      2'b01:   rate_div = 4'd2;
      2'b10:   rate_div = 4'd4;
      default: rate_div = 4'd10;
    endcase
  endfunction
endpackage

// File: rtl/lr_boundary.sv
module lr_boundary
  import link_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_start,
  input  logic       pkt_end,
  input  rate_code_t busy_rate,
  input  rate_code_t idle_rate,
  output rate_code_t pend_next,
  output rate_code_t pend_q
);
  // Start has priority over end when both arrive together.
  always_comb begin
    if (pkt_start)    pend_next = busy_rate;
    else if (pkt_end) pend_next = idle_rate;
    else              pend_next = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= RATE_SLOWEST;
    else        pend_q <= pend_next;
  end

  p_pend_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> pend_q == $past(busy_rate));
  p_pend_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !pkt_start) |=> pend_q == $past(idle_rate));
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && !pkt_end) |=> $stable(pend_q));
endmodule

// File: rtl/lr_divider.sv
module lr_divider
  import link_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rate_code_t pend_next,
  output logic       bit_en,
  output rate_code_t cur_code
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;
  logic             period_done;

  assign period      = rate_div(cur_code);
  assign period_done = (cnt_q == period - 4'd1);
  assign bit_en      = period_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cur_code <= RATE_SLOWEST;
    end else if (period_done) begin
      cnt_q    <= '0;
      cur_code <= pend_next;
    end else begin
      cnt_q    <= cnt_q + 4'd1;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period);
  p_no_short_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rate_div(pend_next) != 4'd1 && cur_code != 2'b00) |=> !bit_en);
  p_code_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cur_code));
  p_code_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> cur_code == $past(pend_next));
endmodule

// File: rtl/link_rate_sel.sv
module link_rate_sel
  import link_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_start,
  input  logic       pkt_end,
  input  logic [1:0] busy_rate,
  input  logic [1:0] idle_rate,
  output logic       bit_en,
  output logic [1:0] rate_code
);
  rate_code_t pend_next;
  rate_code_t pend_q;
  rate_code_t cur_code;

  lr_boundary u_boundary (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .pkt_end   (pkt_end),
    .busy_rate (busy_rate),
    .idle_rate (idle_rate),
    .pend_next (pend_next),
    .pend_q    (pend_q)
  );

  lr_divider u_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_next (pend_next),
    .bit_en    (bit_en),
    .cur_code  (cur_code)
  );

  assign rate_code = cur_code;

  p_out_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && !pkt_end && pend_q == cur_code) |=> $stable(rate_code));
endmodule

// File: tb/link_rate_sel_tb.sv
module link_rate_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_start = 1'b0;
  logic       pkt_end = 1'b0;
  logic [1:0] busy_rate = 2'b00;
  logic [1:0] idle_rate = 2'b00;
  logic       bit_en;
  logic [1:0] rate_code;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  link_rate_sel u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .busy_rate(busy_rate), .idle_rate(idle_rate),
    .bit_en(bit_en), .rate_code(rate_code)
  );

  // Period model from R1..R6: cycles per bit, indexed by code.
  int spacing [4] = '{1, 2, 4, 10};
  int m_age;       // cycles elapsed since last pulse (or reset)
  int m_code;
  int m_pend;

  function automatic bit model_pulse();
    return (m_age + 1) == spacing[m_code];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_age = 0; m_code = 3; m_pend = 3;
    end else begin
      bit fire;
      fire = model_pulse();
      if (pkt_start)    m_pend = int'(busy_rate);
      else if (pkt_end) m_pend = int'(idle_rate);
      if (fire) begin m_age = 0; m_code = m_pend; end
      else m_age = m_age + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: compare outputs mid-cycle, then drive next inputs.
  task automatic step(input bit s, input bit e);
    @(negedge clk);
    check(bit_en == model_pulse(), "R2 bit_en", int'(bit_en), int'(model_pulse()));
    check(int'(rate_code) == m_code, "R4 rate_code", int'(rate_code), m_code);
    pkt_start = s; pkt_end = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  // {busy, idle, gap, length}
  localparam int NV = 8;
  localparam logic [1:0] V_BUSY [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b10, 2'b01, 2'b00};
  localparam logic [1:0] V_IDLE [NV] = '{2'b11, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b11, 2'b11};
  localparam int         V_GAP  [NV] = '{12, 7, 25, 3, 9, 14, 5, 20};
  localparam int         V_LEN  [NV] = '{15, 9, 30, 22, 6, 17, 11, 40};

  int watchdog = 0;
  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", watchdog);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int first;
    int cyc;
    int last_pulse;
    int gap_seen;
    busy_rate = 2'b00; idle_rate = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and first pulse on the tenth cycle.
    check(rate_code == 2'b11, "R1 reset code", int'(rate_code), 3);
    check(bit_en == 1'b0, "R1 reset bit_en", int'(bit_en), 0);
    first = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (bit_en && first == 0) first = i;
    end
    check(first == 9, "R1 first pulse cycle", first, 9);
    // The model started at reset too; resync by running it from here.

    // Table-driven packets.
    for (int v = 0; v < NV; v++) begin
      idle_rate = V_IDLE[v];
      busy_rate = V_BUSY[v];
      idle(V_GAP[v]);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      // R5: mid-packet edits must stay hidden.
      busy_rate = ~V_BUSY[v];
      idle_rate = ~V_IDLE[v];
      idle(V_LEN[v]);
      idle_rate = V_IDLE[v];
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      busy_rate = V_BUSY[v];
    end
    idle(20);

    // R5: directed - change both codes outside any boundary, code stays.
    begin
      logic [1:0] held;
      held = rate_code;
      busy_rate = 2'b00; idle_rate = 2'b00;
      idle(30);
      check(rate_code == held, "R5 no boundary no change", int'(rate_code), int'(held));
    end

    // R3: start and end together - start wins (busy=01, idle=11).
    busy_rate = 2'b01; idle_rate = 2'b11;
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    idle(12);
    check(rate_code == 2'b01, "R3 start priority", int'(rate_code), 1);

    // R2/R6: spacing at divide-by-4 after a change from divide-by-2.
    busy_rate = 2'b10;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    idle(6);
    last_pulse = -1; gap_seen = 0; cyc = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(bit_en == model_pulse(), "R2 bit_en", int'(bit_en), int'(model_pulse()));
      if (bit_en) begin
        if (last_pulse >= 0) gap_seen = cyc - last_pulse;
        last_pulse = cyc;
      end
      cyc++;
    end
    check(gap_seen == 4, "R6 divide-by-4 spacing", gap_seen, 4);

    // R2: divide-by-1 pulses on every cycle.
    busy_rate = 2'b00;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    idle(6);
    @(negedge clk);
    check(bit_en == 1'b1, "R2 full rate pulse", int'(bit_en), 1);
    @(negedge clk);
    check(bit_en == 1'b1, "R2 full rate pulse", int'(bit_en), 1);
    pkt_start = 1'b0; pkt_end = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule